// File: doc/BRIEF.md
# Permission-Gated Wavefront Issue Arbiter

This block picks at most one wavefront to issue on each cycle in a many-threaded core. A wavefront is eligible when it is live, its ready bit is set and its permission bit is set. When the optional static cap is switched on, it must also be among the oldest live wavefronts that the cap admits. The grant goes to the eligible wavefront that ranks highest under the selected priority order. The grant is one-hot and comes with a valid flag.

Wavefront age follows assignment order. A wavefront becomes live on an assignment pulse and stops being live on a retire pulse. Two priority orders are available. Greedy-then-oldest keeps issuing the same wavefront until it stalls, then falls back to the oldest eligible one. Loose round-robin searches upward and wraps from a rotating pointer.

The policy select and the cap settings are captured only while no wavefront is live, so they are fixed for the whole of a kernel. A three-state machine controls the block:
- ST_IDLE: nothing is live and the configuration is tracked.
- ST_GREEDY: the greedy-then-oldest order is active.
- ST_ROTATE: the round-robin order is active.

The block moves from ST_IDLE to ST_GREEDY or ST_ROTATE on the first assignment, following the policy input (0 selects greedy, 1 selects round-robin). It returns to ST_IDLE from either running state when the last live wavefront retires. The grant is combinational from the inputs and the registered state, so it appears in the same cycle as the ready and permission bits.

Top module: `wf_issue_arbiter`

## Requirements
- R1: A wavefront is granted only if it is live, its ready bit is set and its permission bit is set. A ready wavefront that was never assigned receives no grant.
- R2: At most one grant bit is high in any cycle. grant_valid is high exactly when some wavefront is eligible.
- R3: In greedy mode (policy_sel=0 when the kernel starts), the most recently granted wavefront is granted again for as long as it stays eligible, even when older wavefronts are eligible too.
- R4: In greedy mode, when the previous grantee is not eligible, the eligible wavefront assigned earliest is granted.
- R5: In round-robin mode (policy_sel=1 when the kernel starts), the search starts at the pointer slot and goes upward, wrapping from NUM_WF-1 to 0. The first eligible slot is granted.
- R6: After a round-robin grant to slot g, the pointer becomes g+1, or 0 when g is NUM_WF-1. A cycle with no grant leaves the pointer unchanged. The pointer is 0 at the start of every kernel.
- R7: With cap_en=1, only the cap_val oldest live wavefronts may be granted. A younger wavefront gets no grant even when it is ready and permitted. With cap_en=0 there is no limit.
- R8: When a wavefront inside the capped set retires, the next oldest live wavefront joins the set and can be granted.
- R9: policy_sel, cap_en and cap_val are sampled only while no wavefront is live. Changes to them while a kernel runs have no effect on grants.
- R10: After reset no wavefront is live, the machine is in ST_IDLE, and grant and grant_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Assign a wavefront slot this cycle |
| alloc_wf | input | 3 | Slot being assigned |
| retire_valid | input | 1 | Retire a wavefront slot this cycle |
| retire_wf | input | 3 | Slot being retired |
| ready | input | 8 | Per-slot ready to issue |
| permit | input | 8 | Per-slot issue permission |
| policy_sel | input | 1 | 0 greedy-then-oldest, 1 loose round-robin |
| cap_en | input | 1 | Enable the static wavefront cap |
| cap_val | input | 4 | Number of oldest live wavefronts admitted |
| grant | output | 8 | One-hot issue grant |
| grant_valid | output | 1 | A grant is given this cycle |

## Verification
Four properties are checked on every cycle:
- the grant is one-hot and lands only on a ready, permitted wavefront;
- the greedy order never drops a grantee that stays eligible;
- the captured configuration never moves while a kernel runs;
- the capped set never holds more wavefronts than the cap admits, and exactly one live wavefront is oldest.

Only the bench's scenarios can show three further behaviours:
- age order after scattered assignments;
- the wrap-around path of the round-robin pointer;
- promotion of the next oldest wavefront when a capped one retires.

// File: rtl/wfarb_pkg.sv
package wfarb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GREEDY = 2'd1,
        ST_ROTATE = 2'd2
    } arb_state_e;
endpackage

// File: rtl/wf_age_tracker.sv
module wf_age_tracker #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [IW-1:0] alloc_wf,
    input  logic          retire_valid,
    input  logic [IW-1:0] retire_wf,
    input  logic          cap_en,
    input  logic [CW-1:0] cap_val,
    output logic [N-1:0]  live_q,
    output logic [N-1:0]  live_nxt,
    output logic [N-1:0][N-1:0] older_q,
    output logic [N-1:0]  active
);
    // older_q[i][j] set: slot j was assigned before slot i
    logic [CW-1:0] rank [N];
    logic [N-1:0]  rank0;

    always_comb begin
        live_nxt = live_q;
        if (alloc_valid)  live_nxt[alloc_wf]  = 1'b1;
        if (retire_valid) live_nxt[retire_wf] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q  <= '0;
            older_q <= '0;
        end else begin
            live_q <= live_nxt;
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc_valid && alloc_wf == IW'(i))
                        older_q[i][j] <= live_q[j] && (i != j);
                    else if (alloc_valid && alloc_wf == IW'(j))
                        older_q[i][j] <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_rank
        always_comb begin
            rank[g] = '0;
            for (int j = 0; j < N; j++)
                rank[g] = rank[g] + CW'(older_q[g][j] & live_q[j]);
        end
        assign rank0[g]  = live_q[g] && (rank[g] == '0);
        assign active[g] = live_q[g] && (!cap_en || (rank[g] < cap_val));
    end

    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> ($countones(active) <= int'(cap_val)));  // R7
    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (|live_q) |-> $onehot(rank0));  // R4
endmodule

// File: rtl/wf_pick.sv
module wf_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic               rotate,
    input  logic [N-1:0]       elig,
    input  logic [N-1:0][N-1:0] older,
    input  logic               last_vld,
    input  logic [IW-1:0]      last_wf,
    input  logic [IW-1:0]      rr_ptr,
    output logic [N-1:0]       pick_oh
);
    logic [N-1:0] oldest_oh;
    logic [N-1:0] greedy_oh;
    logic [N-1:0] rr_oh;

    for (genvar g = 0; g < N; g++) begin : g_old
        assign oldest_oh[g] = elig[g] && ((older[g] & elig) == '0);
    end

    always_comb begin
        greedy_oh = oldest_oh;
        if (last_vld && elig[last_wf]) begin
            greedy_oh = '0;
            greedy_oh[last_wf] = 1'b1;
        end
    end

    always_comb begin
        logic [IW:0] pos;
        logic        hit;
        rr_oh = '0;
        hit   = 1'b0;
        for (int k = 0; k < N; k++) begin
            pos = {1'b0, rr_ptr} + (IW+1)'(k);
            if (pos >= (IW+1)'(N)) pos = pos - (IW+1)'(N);
            if (!hit && elig[pos[IW-1:0]]) begin
                rr_oh[pos[IW-1:0]] = 1'b1;
                hit = 1'b1;
            end
        end
    end

    assign pick_oh = rotate ? rr_oh : greedy_oh;
endmodule

// File: rtl/wf_issue_arbiter.sv
module wf_issue_arbiter #(
    parameter int NUM_WF = 8,
    localparam int IW = $clog2(NUM_WF),
    localparam int CW = $clog2(NUM_WF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [IW-1:0]     alloc_wf,
    input  logic              retire_valid,
    input  logic [IW-1:0]     retire_wf,
    input  logic [NUM_WF-1:0] ready,
    input  logic [NUM_WF-1:0] permit,
    input  logic              policy_sel,
    input  logic              cap_en,
    input  logic [CW-1:0]     cap_val,
    output logic [NUM_WF-1:0] grant,
    output logic              grant_valid
);
    import wfarb_pkg::*;

    arb_state_e st_q, st_d;
    logic          cfg_rr_q, cfg_cap_en_q;
    logic [CW-1:0] cfg_cap_q;
    logic [NUM_WF-1:0] live_q, live_nxt, active, elig, pick_oh;
    logic [NUM_WF-1:0][NUM_WF-1:0] older_q;
    logic          last_vld_q;
    logic [IW-1:0] last_wf_q, rr_ptr_q, gidx;

    wf_age_tracker #(.N(NUM_WF), .IW(IW), .CW(CW)) u_age (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_wf(alloc_wf),
        .retire_valid(retire_valid), .retire_wf(retire_wf),
        .cap_en(cfg_cap_en_q), .cap_val(cfg_cap_q),
        .live_q(live_q), .live_nxt(live_nxt),
        .older_q(older_q), .active(active)
    );

    assign elig = ready & permit & active;

    wf_pick #(.N(NUM_WF), .IW(IW)) u_pick (
        .rotate(st_q == ST_ROTATE), .elig(elig), .older(older_q),
        .last_vld(last_vld_q), .last_wf(last_wf_q), .rr_ptr(rr_ptr_q),
        .pick_oh(pick_oh)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (|live_nxt) st_d = policy_sel ? ST_ROTATE : ST_GREEDY;
            ST_GREEDY: if (!(|live_nxt)) st_d = ST_IDLE;
            ST_ROTATE: if (!(|live_nxt)) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        grant = '0;
        unique case (st_q)
            ST_GREEDY, ST_ROTATE: grant = pick_oh;
            default:              grant = '0;
        endcase
        grant_valid = |grant;
    end

    always_comb begin
        gidx = '0;
        for (int i = 0; i < NUM_WF; i++)
            if (grant[i]) gidx = IW'(i);
    end

    // configuration capture and per-kernel priority state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rr_q     <= 1'b0;
            cfg_cap_en_q <= 1'b0;
            cfg_cap_q    <= '0;
            last_vld_q   <= 1'b0;
            last_wf_q    <= '0;
            rr_ptr_q     <= '0;
        end else if (st_q == ST_IDLE) begin
            cfg_rr_q     <= policy_sel;
            cfg_cap_en_q <= cap_en;
            cfg_cap_q    <= cap_val;
            last_vld_q   <= 1'b0;
            rr_ptr_q     <= '0;
        end else if (grant_valid) begin
            last_vld_q <= 1'b1;
            last_wf_q  <= gidx;
            rr_ptr_q   <= (gidx == IW'(NUM_WF - 1)) ? '0 : gidx + 1'b1;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R2
    AST_ELIG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ready & permit & active)) && st_q != ST_IDLE) |-> grant_valid);  // R2
    AST_GRANT_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(ready & permit & live_q)) == '0);  // R1
    AST_GREEDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GREEDY && grant_valid) |=>
        (st_q != ST_GREEDY || (($past(grant) & ready & permit & active) == '0)
         || grant == $past(grant)));  // R3
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> ($stable(cfg_rr_q) && $stable(cfg_cap_q)
         && $stable(cfg_cap_en_q)));  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !grant_valid);  // R10
endmodule

// File: tb/sim_wf_issue_arbiter.sv
module sim_wf_issue_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0, retire_valid = 1'b0;
    logic [2:0] alloc_wf = '0, retire_wf = '0;
    logic [7:0] ready = '0, permit = '0;
    logic       policy_sel = 1'b0, cap_en = 1'b0;
    logic [3:0] cap_val = '0;
    logic [7:0] grant;
    logic       grant_valid;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wf_issue_arbiter #(.NUM_WF(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_wf(alloc_wf),
        .retire_valid(retire_valid), .retire_wf(retire_wf),
        .ready(ready), .permit(permit), .policy_sel(policy_sel),
        .cap_en(cap_en), .cap_val(cap_val),
        .grant(grant), .grant_valid(grant_valid)
    );

    // {ready, permit, expected grant}; 0..8 greedy over ages 5,2,7,0; 9..16 round-robin
    localparam logic [23:0] VEC [17] = '{
        {8'hFF, 8'hFF, 8'h20},  // R4 oldest
        {8'hFF, 8'hFF, 8'h20},  // R3 hold
        {8'hDF, 8'hFF, 8'h04},  // R4 stall -> next oldest
        {8'hFF, 8'hFF, 8'h04},  // R3 greedy beats older
        {8'hFF, 8'hFB, 8'h20},  // R1 permission gate
        {8'h81, 8'hFF, 8'h80},  // R4 slot 7 older than slot 0
        {8'h00, 8'hFF, 8'h00},  // R2 none eligible
        {8'h81, 8'hFF, 8'h80},  // R3 resume greedy
        {8'h02, 8'hFF, 8'h00},  // R1 not live
        {8'hFF, 8'hFF, 8'h01},  // R5 ptr 0
        {8'hFF, 8'hFF, 8'h02},  // R6 ptr 1
        {8'h01, 8'hFF, 8'h01},  // R5 wrap
        {8'h30, 8'hFF, 8'h10},  // R5
        {8'h30, 8'hFF, 8'h20},  // R6
        {8'h30, 8'hDF, 8'h10},  // R5 wrap past permit
        {8'h00, 8'hFF, 8'h00},  // R6 no grant keeps ptr
        {8'hFF, 8'hFF, 8'h20}   // R6 ptr held at 5
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp || grant_valid !== (exp != 0)) begin
            fails++;
            $display("FAIL %s grant=%h valid=%b expected grant=%h valid=%b",
                     req, got, grant_valid, exp, exp != 0);
        end
    endtask

    task automatic assign_wf(input logic [2:0] id);
        ready = '0; alloc_valid = 1'b1; alloc_wf = id;
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic retire(input logic [2:0] id);
        ready = '0; retire_valid = 1'b1; retire_wf = id;
        @(posedge clk); #1;
        retire_valid = 1'b0;
    endtask

    task automatic step(input logic [7:0] r, input logic [7:0] p,
                        input logic [7:0] exp, input string req);
        ready = r; permit = p;
        @(negedge clk);
        chk(req, grant, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 reset", grant, 8'h00);
        rst_n = 1'b1;
        @(posedge clk); #1;
        ready = 8'hFF; permit = 8'hFF;
        @(negedge clk);
        chk("R10 nothing live", grant, 8'h00);
        @(posedge clk); #1;

        policy_sel = 1'b0;
        assign_wf(3'd5); assign_wf(3'd2); assign_wf(3'd7); assign_wf(3'd0);
        for (int i = 0; i < 17; i++) begin
            if (i == 9) begin
                retire(3'd5); retire(3'd2); retire(3'd7); retire(3'd0);
                policy_sel = 1'b1;
                @(posedge clk); #1;
                for (int w = 0; w < 8; w++) assign_wf(3'(w));
                policy_sel = 1'b0;  // R9: ignored while running
            end
            step(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
                 (i < 9) ? "R3/R4 greedy vector" : "R5/R6/R9 rotate vector");
        end

        // cap scenario
        for (int w = 0; w < 8; w++) retire(3'(w));
        cap_en = 1'b1; cap_val = 4'd2; policy_sel = 1'b0;
        @(posedge clk); #1;
        assign_wf(3'd3); assign_wf(3'd1); assign_wf(3'd6);
        cap_val = 4'd0; cap_en = 1'b1;  // R9: change mid-kernel ignored
        step(8'hFF, 8'hFF, 8'h08, "R7 oldest inside cap");
        step(8'h40, 8'hFF, 8'h00, "R7 younger outside cap");
        retire(3'd3);
        step(8'h40, 8'hFF, 8'h40, "R8 promoted after retire");
        step(8'h02, 8'hFF, 8'h02, "R8 other member still granted");
        step(8'hFF, 8'hFF, 8'h02, "R3 greedy inside cap");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule